// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a processor from an accepted interrupt request to the first fetch of the matching service routine. It idles until a request is pending and the core reaches a point where it can be interrupted. That point is either the end of the current instruction or any cycle of a long string or repeat-type instruction. From there it runs a fixed 19-cycle microsequence on a byte-wide memory bus. It issues an information read at address zero and clears the source's request. It then saves the flags and rewrites them, writes the old flags and program counter to the stack as four bytes, raises the priority level, and fetches a three-byte routine address from a vector table.

The sequencer writes the flag register, PC, SP and priority level through their own write-enable strobes. It pulses `done_o` once the new PC is loaded, so instruction fetch can resume. Requests that arrive while it is busy wait until the sequence has finished.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a sequence starts only when `req_valid_i` and either `insn_done_i` or `insn_intr_i` are high at a clock edge. `busy_o` is high from the next cycle. Otherwise `busy_o` stays low, even if a request is held for several cycles.
- R2: With `insn_intr_i` high and `insn_done_i` low, a pending request starts the sequence at once, without waiting for an instruction boundary.
- R3: In busy cycle 1, `mem_rd_o` is high with `mem_addr_o` = 0, and `req_clr_o` pulses for exactly that cycle.
- R4: In busy cycle 3, `flg_we_o` is high and `flg_o` equals `flg_i` with bit 6 (interrupt enable) cleared, bit 2 (single step) cleared and bit 7 (stack select) cleared. All other bits are unchanged.
- R5: When the request is a software interrupt (`req_sw_i`) with a number from 32 to 63, bit 7 of `flg_o` keeps its input value in busy cycle 3.
- R6: In busy cycles 4, 6, 8 and 10, single byte writes go to SP-2, SP-1, SP-4 and SP-3 (16-bit wrap, zero-extended address). With F and P the flags and PC sampled in busy cycle 3, the data is F[7:0] at SP-2, {P[19:16],F[11:8]} at SP-1, P[7:0] at SP-4 and P[15:8] at SP-3. Later changes on `flg_i` or `pc_i` do not affect these bytes.
- R7: In busy cycle 12, `ipl_we_o` is high and `ipl_o` carries the accepted request level.
- R8: In busy cycles 13, 15 and 17, reads go to V, V+1 and V+2, where V = VEC_BASE + 4 x number. Read data is taken one cycle after each strobe.
- R9: In busy cycle 19, `done_o`, `pc_we_o` and `sp_we_o` are high. `pc_o` is {byte2[3:0], byte1, byte0} of the vector bytes, and `sp_o` = `sp_i` - 4 (16-bit wrap). `busy_o` is low in the following cycle.
- R10: Request inputs that change while busy, including the done cycle, do not alter the running sequence. A request still held after done starts a new sequence from the idle cycle that follows.
- R11: During and right after reset, every strobe is low and `busy_o` is low.
- R12: `mem_rd_o` and `mem_wr_o` are never high together, and every bus strobe is followed by a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | An accepted request is pending |
| req_num_i | input | NUMW | Interrupt number |
| req_lvl_i | input | LVLW | Request priority level |
| req_sw_i | input | 1 | Request comes from a software interrupt instruction |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| insn_intr_i | input | 1 | A suspendable string or repeat instruction is executing |
| req_clr_o | output | 1 | Clears the acknowledged request bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the new PC is loaded |
| mem_addr_o | output | AW | Bus address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read strobe |
| flg_i | input | FW | Current flag register |
| flg_o | output | FW | New flag value |
| flg_we_o | output | 1 | Flag register write enable |
| pc_i | input | AW | Current program counter |
| pc_o | output | AW | Routine start address |
| pc_we_o | output | 1 | PC write enable |
| sp_i | input | SPW | Current stack pointer |
| sp_o | output | SPW | Adjusted stack pointer |
| sp_we_o | output | 1 | SP write enable |
| ipl_o | output | LVLW | New processor priority level |
| ipl_we_o | output | 1 | Priority level write enable |

## Verification
The assertions assume that `mem_rdata_i` is valid in the cycle after a read strobe. They also assume that `sp_i` stays put for the whole busy period, because stack addresses and the final SP value come from it directly. The stimulus meets both assumptions: a bench memory registers its read data on the strobe edge, and `sp_i` is changed only while the block is idle. The flag and PC inputs are the exception and are toggled on purpose after the snapshot cycle, which shows that the stacked bytes come from the saved copy.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned PUSH_BYTES  = 4;
  localparam int unsigned VEC_BYTES   = 3;
  localparam int unsigned SEQ_CYCLES  = 19;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INFO_A,
    ST_INFO_B,
    ST_FLAGS,
    ST_PUSH_A,
    ST_PUSH_B,
    ST_IPL,
    ST_VEC_A,
    ST_VEC_B,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       insn_done_i,
  input  logic       insn_intr_i,
  output seq_state_e state_o,
  output logic [1:0] idx_o,
  output logic       start_o
);

  seq_state_e state_q, state_n;
  logic [1:0] idx_q, idx_n;

  assign start_o = (state_q == ST_IDLE) && req_valid_i && (insn_done_i || insn_intr_i);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    unique case (state_q)
      ST_IDLE:   if (start_o) state_n = ST_INFO_A;
      ST_INFO_A: state_n = ST_INFO_B;
      ST_INFO_B: state_n = ST_FLAGS;
      ST_FLAGS: begin
        state_n = ST_PUSH_A;
        idx_n   = '0;
      end
      ST_PUSH_A: state_n = ST_PUSH_B;
      ST_PUSH_B: begin
        if (idx_q == 2'(PUSH_BYTES - 1)) begin
          state_n = ST_IPL;
          idx_n   = '0;
        end else begin
          state_n = ST_PUSH_A;
          idx_n   = idx_q + 2'd1;
        end
      end
      ST_IPL: begin
        state_n = ST_VEC_A;
        idx_n   = '0;
      end
      ST_VEC_A: state_n = ST_VEC_B;
      ST_VEC_B: begin
        if (idx_q == 2'(VEC_BYTES - 1)) begin
          state_n = ST_DONE;
          idx_n   = '0;
        end else begin
          state_n = ST_VEC_A;
          idx_n   = idx_q + 2'd1;
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  // R8
  vec_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VEC_A || state_q == ST_VEC_B) |-> idx_q < 2'(VEC_BYTES));

endmodule

// File: rtl/irq_entry_stack.sv
module irq_entry_stack
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned SPW   = 16,
  parameter int unsigned FW    = 12,
  parameter int unsigned I_BIT = 6,
  parameter int unsigned D_BIT = 2,
  parameter int unsigned U_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [1:0]        idx_i,
  input  logic              keep_u_i,
  input  logic [FW-1:0]     flg_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [SPW-1:0]    sp_i,
  output logic [FW-1:0]     flg_o,
  output logic              flg_we_o,
  output logic              wr_o,
  output logic [AW-1:0]     addr_o,
  output logic [BYTE_W-1:0] wdata_o
);

  localparam int unsigned IMGW = FW + AW;

  logic [FW-1:0]   flg_sv;
  logic [AW-1:0]   pc_sv;
  logic [2:0]      off;
  logic [1:0]      img_sel;
  logic [SPW-1:0]  slot;
  logic [IMGW-1:0] img;

  always_comb begin
    flg_o        = flg_i;
    flg_o[I_BIT] = 1'b0;
    flg_o[D_BIT] = 1'b0;
    if (!keep_u_i) flg_o[U_BIT] = 1'b0;
  end

  assign flg_we_o = (state_i == ST_FLAGS);
  assign wr_o     = (state_i == ST_PUSH_A);

  // snapshot taken with the pre-modification flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_sv <= '0;
      pc_sv  <= '0;
    end else if (state_i == ST_FLAGS) begin
      flg_sv <= flg_i;
      pc_sv  <= pc_i;
    end
  end

  // write order 2,1,4,3 below SP
  assign off     = {idx_i[1], ~idx_i[0]} + 3'd1;
  assign img_sel = 2'(3'd4 - off);
  assign slot    = sp_i - SPW'(off);
  assign img     = {pc_sv[AW-1:16], flg_sv, pc_sv[15:0]};

  assign addr_o  = wr_o ? {{(AW-SPW){1'b0}}, slot} : '0;
  assign wdata_o = wr_o ? img[{img_sel, 3'b000} +: BYTE_W] : '0;

  // R4
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_we_o |-> (!flg_o[I_BIT] && !flg_o[D_BIT]));

  // R6
  push_flg_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && idx_i == 2'd0) |-> wdata_o == $past(flg_i[7:0]));

endmodule

// File: rtl/irq_entry_vec.sv
module irq_entry_vec
  import irq_entry_pkg::*;
#(
  parameter int unsigned    AW       = 20,
  parameter int unsigned    NUMW     = 6,
  parameter logic [AW-1:0]  VEC_BASE = 20'hFFDC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [1:0]        idx_i,
  input  logic [NUMW-1:0]   num_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     pc_o
);

  logic [AW-1:0] vaddr;
  logic [AW-1:0] pc_q;

  assign rd_o   = (state_i == ST_VEC_A);
  assign vaddr  = VEC_BASE + AW'({num_i, 2'b00}) + AW'(idx_i);
  assign addr_o = rd_o ? vaddr : '0;

  // high nibble of the third byte is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (state_i == ST_VEC_B) begin
      unique case (idx_i)
        2'd0:    pc_q[7:0]     <= rdata_i;
        2'd1:    pc_q[15:8]    <= rdata_i;
        default: pc_q[AW-1:16] <= rdata_i[AW-17:0];
      endcase
    end
  end

  assign pc_o = pc_q;

  // R8
  vec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && idx_i != 2'd0) |-> addr_o == $past(addr_o, 2) + AW'(1));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned   AW         = 20,
  parameter int unsigned   SPW        = 16,
  parameter int unsigned   FW         = 12,
  parameter int unsigned   NUMW       = 6,
  parameter int unsigned   LVLW       = 3,
  parameter logic [AW-1:0] VEC_BASE   = 20'hFFDC0,
  parameter int unsigned   I_BIT      = 6,
  parameter int unsigned   D_BIT      = 2,
  parameter int unsigned   U_BIT      = 7,
  parameter int unsigned   SW_KEEP_LO = 32,
  parameter int unsigned   SW_KEEP_HI = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [NUMW-1:0]   req_num_i,
  input  logic [LVLW-1:0]   req_lvl_i,
  input  logic              req_sw_i,
  input  logic              insn_done_i,
  input  logic              insn_intr_i,
  output logic              req_clr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic [FW-1:0]     flg_i,
  output logic [FW-1:0]     flg_o,
  output logic              flg_we_o,
  input  logic [AW-1:0]     pc_i,
  output logic [AW-1:0]     pc_o,
  output logic              pc_we_o,
  input  logic [SPW-1:0]    sp_i,
  output logic [SPW-1:0]    sp_o,
  output logic              sp_we_o,
  output logic [LVLW-1:0]   ipl_o,
  output logic              ipl_we_o
);

  localparam int unsigned CNTW = $clog2(SEQ_CYCLES + 1);

  seq_state_e        state;
  logic [1:0]        idx;
  logic              start;
  logic [NUMW-1:0]   num_q;
  logic [LVLW-1:0]   lvl_q;
  logic              sw_q;
  logic              keep_u;
  logic              push_wr, vec_rd, info_rd;
  logic [AW-1:0]     push_addr, vec_addr;
  logic [BYTE_W-1:0] push_wdata;
  logic [CNTW-1:0]   busy_cnt;

  irq_entry_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .insn_done_i (insn_done_i),
    .insn_intr_i (insn_intr_i),
    .state_o     (state),
    .idx_o       (idx),
    .start_o     (start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      lvl_q <= '0;
      sw_q  <= 1'b0;
    end else if (start) begin
      num_q <= req_num_i;
      lvl_q <= req_lvl_i;
      sw_q  <= req_sw_i;
    end
  end

  assign keep_u = sw_q && (int'(num_q) >= int'(SW_KEEP_LO)) && (int'(num_q) <= int'(SW_KEEP_HI));

  irq_entry_stack #(
    .AW(AW), .SPW(SPW), .FW(FW), .I_BIT(I_BIT), .D_BIT(D_BIT), .U_BIT(U_BIT)
  ) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .idx_i    (idx),
    .keep_u_i (keep_u),
    .flg_i    (flg_i),
    .pc_i     (pc_i),
    .sp_i     (sp_i),
    .flg_o    (flg_o),
    .flg_we_o (flg_we_o),
    .wr_o     (push_wr),
    .addr_o   (push_addr),
    .wdata_o  (push_wdata)
  );

  irq_entry_vec #(
    .AW(AW), .NUMW(NUMW), .VEC_BASE(VEC_BASE)
  ) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .idx_i   (idx),
    .num_i   (num_q),
    .rdata_i (mem_rdata_i),
    .rd_o    (vec_rd),
    .addr_o  (vec_addr),
    .pc_o    (pc_o)
  );

  assign info_rd     = (state == ST_INFO_A);
  assign req_clr_o   = info_rd;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign mem_rd_o    = info_rd | vec_rd;
  assign mem_wr_o    = push_wr;
  assign mem_addr_o  = push_addr | vec_addr;  // info read uses address zero
  assign mem_wdata_o = push_wdata;
  assign ipl_o       = lvl_q;
  assign ipl_we_o    = (state == ST_IPL);
  assign pc_we_o     = done_o;
  assign sp_o        = sp_i - SPW'(PUSH_BYTES);
  assign sp_we_o     = done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R12
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R12
  bus_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |=> !(mem_rd_o || mem_wr_o));

  // R3
  info_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_clr_o |-> (mem_rd_o && mem_addr_o == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(req_valid_i && (insn_done_i || insn_intr_i))) |=> !busy_o);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R9
  seq_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_cnt == CNTW'(SEQ_CYCLES - 1));

  // R7
  ipl_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipl_we_o |-> $past(mem_wr_o, 2));

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam logic [19:0] VB = 20'hFFDC0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, sw, idone, iintr;
  logic [5:0]  num;
  logic [2:0]  lvl;
  logic [7:0]  rdata;
  logic [11:0] flg;
  logic [19:0] pc;
  logic [15:0] sp;

  logic        req_clr, busy, done, mem_rd, mem_wr, flg_we, pc_we, sp_we, ipl_we;
  logic [19:0] mem_addr, pc_out;
  logic [7:0]  wdata;
  logic [11:0] flg_out;
  logic [15:0] sp_out;
  logic [2:0]  ipl_out;

  int n_chk  = 0;
  int n_fail = 0;
  string scn = "R11";

  int          m_cyc = 0;
  int          m_num = 0;
  logic [2:0]  m_lvl;
  logic        m_sw;
  logic [11:0] m_flg;
  logic [19:0] m_pc;

  logic [7:0] mem [logic [19:0]];

  always #2 clk = ~clk;

  irq_entry_seq #(.VEC_BASE(VB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req), .req_num_i(num), .req_lvl_i(lvl), .req_sw_i(sw),
    .insn_done_i(idone), .insn_intr_i(iintr),
    .req_clr_o(req_clr), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .flg_i(flg), .flg_o(flg_out), .flg_we_o(flg_we),
    .pc_i(pc), .pc_o(pc_out), .pc_we_o(pc_we),
    .sp_i(sp), .sp_o(sp_out), .sp_we_o(sp_we),
    .ipl_o(ipl_out), .ipl_we_o(ipl_we)
  );

  function automatic logic [7:0] rd_mem(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) rdata <= mem_rd ? rd_mem(mem_addr) : 8'h00;

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s] cyc=%0d: actual %h expected %h", tag, what, scn, m_cyc, act, exp);
    end
  endtask

  function automatic string tag_of(input int c);
    if (c == 0) return "R1";
    if (c <= 2) return "R3";
    if (c == 3) return (m_sw && m_num >= 32) ? "R5" : "R4";
    if (c <= 11) return "R6";
    if (c == 12) return "R7";
    if (c <= 18) return "R8";
    return "R9";
  endfunction

  task automatic compare();
    int c = m_cyc;
    string t = tag_of(c);
    logic [8:0]  e_ctl, a_ctl;
    logic [19:0] e_addr;
    logic [7:0]  e_dat;
    logic [11:0] e_flg;
    logic [19:0] va;
    e_ctl = {c != 0, c == 1 || c == 13 || c == 15 || c == 17,
             c == 4 || c == 6 || c == 8 || c == 10, c == 1, c == 3, c == 12,
             c == 19, c == 19, c == 19};
    a_ctl = {busy, mem_rd, mem_wr, req_clr, flg_we, ipl_we, pc_we, sp_we, done};
    chk({t, "+R12"}, "strobes", 32'(a_ctl), 32'(e_ctl));
    va = VB + 20'(m_num * 4);
    e_addr = 20'h0;
    e_dat  = 8'h00;
    case (c)
      4:  begin e_addr = {4'h0, 16'(sp - 16'd2)}; e_dat = m_flg[7:0]; end
      6:  begin e_addr = {4'h0, 16'(sp - 16'd1)}; e_dat = {m_pc[19:16], m_flg[11:8]}; end
      8:  begin e_addr = {4'h0, 16'(sp - 16'd4)}; e_dat = m_pc[7:0]; end
      10: begin e_addr = {4'h0, 16'(sp - 16'd3)}; e_dat = m_pc[15:8]; end
      13: e_addr = va;
      15: e_addr = va + 20'd1;
      17: e_addr = va + 20'd2;
      default: ;
    endcase
    if (e_ctl[7] || e_ctl[6]) chk(t, "addr", 32'(mem_addr), 32'(e_addr));
    if (e_ctl[6]) chk(t, "wdata", 32'(wdata), 32'(e_dat));
    if (c == 3) begin
      e_flg = flg;
      e_flg[6] = 1'b0;
      e_flg[2] = 1'b0;
      if (!(m_sw && m_num >= 32 && m_num <= 63)) e_flg[7] = 1'b0;
      chk(t, "flags", 32'(flg_out), 32'(e_flg));
    end
    if (c == 12) chk(t, "ipl", 32'(ipl_out), 32'(m_lvl));
    if (c == 19) begin
      chk(t, "pc", 32'(pc_out), 32'({rd_mem(va + 20'd2) & 8'h0F, rd_mem(va + 20'd1), rd_mem(va)}));
      chk(t, "sp", 32'(sp_out), 32'(16'(sp - 16'd4)));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst_n) m_cyc = 0;
    else if (m_cyc == 0) begin
      if (req && (idone || iintr)) begin
        m_cyc = 1; m_num = int'(num); m_lvl = lvl; m_sw = sw;
      end
    end else if (m_cyc == 19) m_cyc = 0;
    else begin
      if (m_cyc == 3) begin m_flg = flg; m_pc = pc; end
      m_cyc++;
    end
    compare();
  endtask

  task automatic run(input logic [5:0] n, input logic [2:0] l, input logic s, input logic intr,
                     input logic [11:0] f, input logic [19:0] p, input logic [15:0] stk, input string tg);
    scn = tg;
    num = n; lvl = l; sw = s; flg = f; pc = p; sp = stk;
    req = 1'b1;
    if (intr) iintr = 1'b1; else idone = 1'b1;
    tick();
    req = 1'b0; idone = 1'b0; iintr = 1'b0;
    for (int i = 0; i < 19; i++) begin
      tick();
      if (m_cyc == 4) begin flg = ~f; pc = ~p; end  // R6 snapshot
    end
    tick();
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; sw = 1'b0; idone = 1'b0; iintr = 1'b0;
    num = '0; lvl = '0; flg = '0; pc = '0; sp = 16'h0400;
    for (int n = 0; n < 64; n++) begin
      mem[VB + 20'(n * 4)]     = 8'(n) ^ 8'h5A;
      mem[VB + 20'(n * 4 + 1)] = 8'hC3 + 8'(n);
      mem[VB + 20'(n * 4 + 2)] = 8'hF0 | (8'(n) & 8'h0F);
    end
    repeat (3) tick();              // R11 reset state
    rst_n = 1'b1;
    tick();

    // R1: request without a boundary stays idle
    scn = "R1"; num = 6'd5; lvl = 3'd3; req = 1'b1;
    repeat (3) tick();
    run(6'd5, 3'd3, 1'b0, 1'b0, 12'hFFF, 20'h12345, 16'h0400, "R1");
    run(6'd40, 3'd5, 1'b1, 1'b1, 12'hAC4, 20'hABCDE, 16'h0800, "R2");
    run(6'd40, 3'd1, 1'b0, 1'b0, 12'h0FF, 20'h00F0F, 16'h1000, "R4");
    run(6'd31, 3'd2, 1'b1, 1'b0, 12'h3C5, 20'h55AA5, 16'h2000, "R5");
    run(6'd32, 3'd6, 1'b1, 1'b0, 12'h9C4, 20'h7F001, 16'h2000, "R5");
    run(6'd63, 3'd7, 1'b1, 1'b1, 12'h5A5, 20'hF0F0F, 16'h0002, "R6");

    // R10: request held through a sequence, inputs change while busy
    scn = "R10"; num = 6'd7; lvl = 3'd4; sw = 1'b0; flg = 12'h123; pc = 20'h4567A; sp = 16'h0300;
    req = 1'b1; idone = 1'b1;
    tick();
    num = 6'd9; lvl = 3'd2;
    repeat (40) tick();
    req = 1'b0; idone = 1'b0;
    repeat (22) tick();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule